// File: doc/BRIEF.md
# Model-Switching Query Queue Scheduler

This block decides which per-model query queue feeds the scoring pipeline. Each model has its own queue of waiting queries, filled by attributes such as query language or type. The scheduler serves one queue at a time, forwarding its head query whenever the downstream side is ready, and keeps serving that queue until it runs dry. Only then does it look for another queue with work in it.

Switching models is expensive. Loading a new model takes far longer than scoring one query, with a budget in the hundreds of microseconds. So every switch to a queue whose model is not already loaded raises a reload request that carries the new model index. Forwarding stops until the loader answers with a done pulse. A reload that never completes is cut off by a cycle-count timeout. The timeout sets a sticky error flag, forgets the loaded model and sends the scheduler back to selection, which then retries.

The queues themselves sit outside the block. Each one shows a non-empty flag and its head entry, and it drops that head when the block pulses the queue's dequeue strobe.

Top module: `model_queue_sched`

## Requirements
- R1: While reset is asserted and just after it is released, rld_req, out_valid, err_tmo and every q_pop bit are 0.
- R2: At most one q_pop bit is set in any cycle. A bit is set only in a cycle where out_valid and out_ready are both 1. The set bit is the one for the queue shown on out_model.
- R3: Once a queue is being served, no query from any other queue is forwarded until that queue is empty, even when other queues are non-empty.
- R4: When the served queue empties, the next queue is the first non-empty one in ascending index order after the drained index, wrapping from NQ-1 to 0. The drained queue itself is considered last. After reset the search starts at queue 0.
- R5: Selecting a queue whose model is not loaded raises rld_req with rld_model equal to the new queue index. Both stay unchanged until rld_done is sampled 1 or the timeout expires.
- R6: While rld_req is 1, out_valid is 0 and no q_pop bit is set.
- R7: If the selected queue's model is already loaded, which includes the case where the drained queue is the only non-empty one, the block serves it with no reload request.
- R8: After reset no model counts as loaded, so the first selection, even of queue 0, raises a reload.
- R9: If rld_done does not arrive, rld_req stays high for exactly TMO_CYC cycles and then falls. err_tmo becomes 1 and stays 1 until reset. The loaded model is forgotten, so the next selection issues a new reload even for the same queue.
- R10: out_query equals the head entry of the queue being served, and out_model equals that queue's index. The entries of one queue leave in the order they were queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| q_nonempty | input | NQ | Per-queue flag: queue holds at least one query |
| q_head | input | NQ*QW | Head entry of every queue, queue i at bits i*QW +: QW |
| q_pop | output | NQ | Per-queue dequeue strobe, one cycle per query taken |
| out_valid | output | 1 | A query is presented downstream |
| out_ready | input | 1 | Downstream accepts the presented query |
| out_query | output | QW | Query being forwarded |
| out_model | output | IW | Index of the queue and model being served |
| rld_req | output | 1 | Model reload request, held until done or timeout |
| rld_model | output | IW | Model to load while rld_req is high |
| rld_done | input | 1 | Loader reports the requested model is in place |
| err_tmo | output | 1 | Sticky flag: a reload timed out |

## Verification
The assertions check on every cycle that forwarding is frozen during a reload, that dequeue strobes are one-hot and tied to accepted transfers, and that the served queue cannot change while it still holds work. They also check that a pending request keeps its model steady until answered, and that the timeout error is sticky. Only the bench scenarios can show the round-robin order across drains and the wrap past the last index. The same holds for skipping the reload when the drained queue refills, the exact timeout length, and the retry after it. Each of these depends on a queue history that a single-cycle property does not see.

// File: rtl/qsched_pkg.sv
package qsched_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_RELOAD = 2'd1,
    S_SERVE  = 2'd2
  } sched_st_t;
endpackage

// File: rtl/qsched_rr_pick.sv
// Round-robin pick: first requesting index after 'last', with 'last' itself tried last.
module qsched_rr_pick #(
  parameter int NQ = 4,
  parameter int IW = 2
) (
  input  logic [NQ-1:0] req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] grant,
  output logic          any
);
  always_comb begin
    grant = '0;
    any   = |req;
    // Walk from farthest to nearest so the nearest requester wins.
    for (int k = NQ; k >= 1; k--) begin
      automatic int idx = (int'(last) + k) % NQ;
      if (req[idx]) grant = IW'(idx);
    end
  end
endmodule

// File: rtl/qsched_rld_timer.sv
// Counts cycles while a reload is pending; flags the last allowed cycle.
module qsched_rld_timer #(
  parameter int TMO_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign expired = run && (cnt_q == CW'(TMO_CYC - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!run)          cnt_d = '0;
    else if (!expired) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_TMR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/model_queue_sched.sv
module model_queue_sched
  import qsched_pkg::*;
#(
  parameter int NQ      = 4,
  parameter int QW      = 32,
  parameter int TMO_CYC = 50000,
  localparam int IW     = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NQ-1:0]    q_nonempty,
  input  logic [NQ*QW-1:0] q_head,
  output logic [NQ-1:0]    q_pop,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [QW-1:0]    out_query,
  output logic [IW-1:0]    out_model,
  output logic             rld_req,
  output logic [IW-1:0]    rld_model,
  input  logic             rld_done,
  output logic             err_tmo
);
  sched_st_t st_q, st_d;
  logic [IW-1:0] cur_q, cur_d;
  logic          ld_ok_q, ld_ok_d;   // model of cur_q is resident
  logic          err_q, err_d;
  logic [IW-1:0] pick_idx;
  logic          pick_any;
  logic          tmo_hit;
  logic          xfer;

  qsched_rr_pick #(.NQ(NQ), .IW(IW)) u_pick (
    .req   (q_nonempty),
    .last  (cur_q),
    .grant (pick_idx),
    .any   (pick_any)
  );

  qsched_rld_timer #(.TMO_CYC(TMO_CYC)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == S_RELOAD),
    .expired (tmo_hit)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    ld_ok_d = ld_ok_q;
    err_d   = err_q;
    unique case (st_q)
      S_IDLE: begin
        if (pick_any) begin
          cur_d = pick_idx;
          st_d  = (ld_ok_q && (pick_idx == cur_q)) ? S_SERVE : S_RELOAD;
        end
      end
      S_RELOAD: begin
        if (rld_done) begin
          st_d    = S_SERVE;
          ld_ok_d = 1'b1;
        end else if (tmo_hit) begin
          st_d    = S_IDLE;
          ld_ok_d = 1'b0;
          err_d   = 1'b1;
        end
      end
      S_SERVE: begin
        if (!q_nonempty[cur_q]) st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      cur_q   <= IW'(NQ - 1);
      ld_ok_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      ld_ok_q <= ld_ok_d;
      err_q   <= err_d;
    end
  end

  // Outputs
  assign out_valid = (st_q == S_SERVE) && q_nonempty[cur_q];
  assign out_query = q_head[cur_q*QW +: QW];
  assign out_model = cur_q;
  assign xfer      = out_valid && out_ready;
  assign rld_req   = (st_q == S_RELOAD);
  assign rld_model = cur_q;
  assign err_tmo   = err_q;

  for (genvar g = 0; g < NQ; g++) begin : g_pop
    assign q_pop[g] = xfer && (cur_q == IW'(g));
  end

  AST_POP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_pop)); // R2
  AST_POP_ON_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (q_pop != '0) |-> (out_valid && out_ready)); // R2
  AST_STAY_WHILE_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == S_SERVE) && q_nonempty[cur_q]) |=> $stable(cur_q)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rld_req && !rld_done && !tmo_hit) |=> (rld_req && $stable(rld_model))); // R5
  AST_NO_FWD_IN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rld_req |-> (!out_valid && (q_pop == '0))); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_tmo |=> err_tmo); // R9
  AST_TMO_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_hit && !rld_done) |=> (!rld_req && err_tmo)); // R9
endmodule

// File: tb/model_queue_sched_test.sv
module model_queue_sched_test;
  localparam int NQ  = 4;
  localparam int QW  = 16;
  localparam int TMO = 40;
  localparam int IW  = 2;
  localparam int FD  = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic [NQ-1:0]    q_nonempty;
  logic [NQ*QW-1:0] q_head;
  logic [NQ-1:0]    q_pop;
  logic             out_valid, out_ready;
  logic [QW-1:0]    out_query;
  logic [IW-1:0]    out_model;
  logic             rld_req, rld_done, err_tmo;
  logic [IW-1:0]    rld_model;

  always #5 clk = ~clk;

  model_queue_sched #(.NQ(NQ), .QW(QW), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .q_nonempty(q_nonempty), .q_head(q_head),
    .q_pop(q_pop), .out_valid(out_valid), .out_ready(out_ready),
    .out_query(out_query), .out_model(out_model), .rld_req(rld_req),
    .rld_model(rld_model), .rld_done(rld_done), .err_tmo(err_tmo)
  );

  // Queue models
  logic [QW-1:0] mem [NQ][FD];
  int            cnt [NQ];
  logic          push_en;
  int            push_q;
  logic [QW-1:0] push_val;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      q_nonempty[q]        = (cnt[q] != 0);
      q_head[q*QW +: QW]   = mem[q][0];
    end
  end

  always @(posedge clk) begin
    for (int q = 0; q < NQ; q++) begin
      if (q_pop[q]) for (int i = 0; i < FD-1; i++) mem[q][i] <= mem[q][i+1];
      if (push_en && push_q == q) mem[q][cnt[q] - (q_pop[q] ? 1 : 0)] <= push_val;
      cnt[q] <= cnt[q] - (q_pop[q] ? 1 : 0) + ((push_en && push_q == q) ? 1 : 0);
    end
  end

  // Loader responder
  logic auto_done;
  int   rld_lat, lat_cnt;
  always @(posedge clk) begin
    rld_done <= 1'b0;
    if (auto_done && rld_req && !rld_done) begin
      if (lat_cnt == rld_lat) begin rld_done <= 1'b1; lat_cnt <= 0; end
      else lat_cnt <= lat_cnt + 1;
    end else lat_cnt <= 0;
  end

  // Monitors
  logic [QW-1:0] lg_q [64];
  int            lg_m [64];
  int            rl_m [32];
  int n_out, n_rl, run, last_run, v2, v6;
  always @(posedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && n_out < 64) begin
        lg_q[n_out] = out_query; lg_m[n_out] = int'(out_model); n_out++;
      end
      if (rld_req && rld_done && n_rl < 32) begin rl_m[n_rl] = int'(rld_model); n_rl++; end
      if (rld_req) run++;
      else if (run != 0) begin last_run = run; run = 0; end
      if (q_pop != '0 && (q_pop != (NQ'(1) << out_model) || !out_valid || !out_ready)) v2++;
      if (rld_req && (out_valid || q_pop != '0)) v6++;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic check(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic push(int q, int v);
    @(negedge clk);
    push_en = 1'b1; push_q = q; push_val = QW'(v);
    @(negedge clk);
    push_en = 1'b0;
  endtask

  task automatic wait_quiet();
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (q_nonempty == '0 && !rld_req && !out_valid) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_out(string rq, int idx, int val, int mdl);
    check(rq, int'(lg_q[idx]), val);
    check(rq, lg_m[idx], mdl);
  endtask

  task automatic t_reset();
    check("R1 rld_req", int'(rld_req), 0);
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 err_tmo", int'(err_tmo), 0);
    check("R1 q_pop", int'(q_pop), 0);
  endtask

  task automatic t_first_and_refill();
    int o0, r0;
    o0 = n_out; r0 = n_rl;
    push(0, 'h0A01); push(0, 'h0A02); push(0, 'h0A03);
    wait_quiet();
    check("R8 first reload count", n_rl - r0, 1);
    check("R8 first reload model", rl_m[r0], 0);
    check("R10 count", n_out - o0, 3);
    check_out("R10 order", o0,     'h0A01, 0);
    check_out("R10 order", o0 + 1, 'h0A02, 0);
    check_out("R10 order", o0 + 2, 'h0A03, 0);
    o0 = n_out; r0 = n_rl;
    push(0, 'h0A04); push(0, 'h0A05);
    wait_quiet();
    check("R7 no reload on refill", n_rl - r0, 0);
    check_out("R7 refill served", o0,     'h0A04, 0);
    check_out("R7 refill served", o0 + 1, 'h0A05, 0);
  endtask

  task automatic t_drain_and_rotate();
    int o0, r0;
    o0 = n_out; r0 = n_rl;
    out_ready = 1'b0;
    push(0, 'h0B01); push(0, 'h0B02);
    push(2, 'h2B01); push(2, 'h2B02);
    push(1, 'h1B01); push(3, 'h3B01);
    out_ready = 1'b1;
    wait_quiet();
    check("R3 total", n_out - o0, 6);
    check_out("R3 stay on queue 0", o0,     'h0B01, 0);
    check_out("R3 stay on queue 0", o0 + 1, 'h0B02, 0);
    check_out("R4 next after 0", o0 + 2, 'h1B01, 1);
    check_out("R4 then 2", o0 + 3, 'h2B01, 2);
    check_out("R4 then 2", o0 + 4, 'h2B02, 2);
    check_out("R4 then 3", o0 + 5, 'h3B01, 3);
    check("R5 reload count", n_rl - r0, 3);
    check("R5 reload model", rl_m[r0],     1);
    check("R5 reload model", rl_m[r0 + 1], 2);
    check("R5 reload model", rl_m[r0 + 2], 3);
  endtask

  task automatic t_wrap_and_hold();
    int o0, r0;
    o0 = n_out; r0 = n_rl;
    rld_lat = 12;
    out_ready = 1'b0;
    push(0, 'h0C01); push(1, 'h1C01);
    out_ready = 1'b1;
    wait_quiet();
    check("R4 wrap reload count", n_rl - r0, 2);
    check("R4 wrap to 0", rl_m[r0], 0);
    check("R4 then 1", rl_m[r0 + 1], 1);
    check_out("R4 wrap data", o0,     'h0C01, 0);
    check_out("R4 wrap data", o0 + 1, 'h1C01, 1);
    check("R5 request held until done", last_run, rld_lat + 2);
    check("R6 no forwarding in reload", v6, 0);
    check("R2 strobe discipline", v2, 0);
    rld_lat = 3;
  endtask

  task automatic t_timeout();
    int o0, r0;
    o0 = n_out; r0 = n_rl;
    auto_done = 1'b0;
    push(2, 'h2D01);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (err_tmo) break;
    end
    repeat (2) @(negedge clk);
    check("R9 err set", int'(err_tmo), 1);
    check("R9 request length", last_run, TMO);
    check("R9 nothing forwarded", n_out - o0, 0);
    auto_done = 1'b1;
    wait_quiet();
    check("R9 retry reload", n_rl - r0, 1);
    check("R9 retry model", rl_m[r0], 2);
    check_out("R9 served after retry", o0, 'h2D01, 2);
    check("R9 err sticky", int'(err_tmo), 1);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; out_ready = 1'b1; auto_done = 1'b1; rld_lat = 3;
    push_en = 1'b0; push_q = 0; push_val = '0;
    n_out = 0; n_rl = 0; run = 0; last_run = 0; v2 = 0; v6 = 0;
    for (int q = 0; q < NQ; q++) cnt[q] = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_and_refill();
    t_drain_and_rotate();
    t_wrap_and_hold();
    t_timeout();
    check("R6 no forwarding in reload", v6, 0);
    check("R2 strobe discipline", v2, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule